// File: doc/BRIEF.md
# Sequential Instruction Fetch Address Unit

This block keeps the program counter of a simple single-cycle processor and produces the address sent to a clocked instruction memory. Each cycle it forms the next counter value. That is the current counter plus one word. It loads this value into the counter on the rising clock edge. The flow is strictly sequential and has no branch or jump path.

The memory address port carries the next-counter value, not the counter register output. The memory captures that address on the same edge that loads the counter. So the word the memory returns always belongs to the address now held in the counter. Reset loads an address one word below the first instruction, so the first fetch after reset goes to the program start.

The instruction word from the memory passes through to the decode stage unchanged. The memory interface has no handshake, because a clocked memory returns one word per cycle with no stall. The interface is therefore plain.

Top module: `pcu_fetch`

## Requirements
- R1: While `rst` is high, `fetch_addr` equals the reset value `RESET_PC` (default 32'h003FFFFC).
- R2: A rising clock edge with `rst` high loads `pc` with `RESET_PC`.
- R3: While `rst` is low, `fetch_addr` equals `pc + 4`, taken modulo 2^ADDR_W.
- R4: On every rising edge, `pc` takes the value `fetch_addr` held just before that edge.
- R5: After reset is released, the first fetch is from 32'h00400000. After N edges with `rst` low, `pc` equals 32'h00400000 + 4*(N-1).
- R6: `instr` equals `imem_rdata` unchanged. With a memory that registers `fetch_addr` on the clock edge, `instr` is the word stored at `pc`.
- R7: The address sequence wraps from 32'hFFFFFFFC to 32'h00000000 with no gap.
- R8: Raising `rst` in the middle of a run restarts the sequence. The next release behaves exactly as the first release does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_rdata | input | DATA_W | Word returned by the clocked instruction memory |
| pc | output | ADDR_W | Program counter register |
| fetch_addr | output | ADDR_W | Next-counter value, used as the instruction memory address |
| instr | output | DATA_W | Instruction word passed through to decode |

## Verification
Embedded properties check four things on every cycle:
- the reset value appears on the address port while reset is held (R1);
- reset loads the counter (R2);
- the counter follows the pre-edge address (R4);
- the counter steps by one word while out of reset (R5).

Only the bench scenarios show the rest. These are the absolute address sequence counted from the program start, and the alignment between the fetched word and the counter when a clocked memory model is attached. They also cover wrap-around at the top of the address space and restarts after reset is raised mid-run.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int unsigned PCU_ADDR_W   = 32;
  localparam int unsigned PCU_DATA_W   = 32;
  localparam int unsigned PCU_WORD_BYTES = 4;
  localparam logic [PCU_ADDR_W-1:0] PCU_RESET_PC = 32'h003F_FFFC;
endpackage

// File: rtl/pcu_next.sv
module pcu_next #(
  parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W,
  parameter int unsigned STEP = pcu_pkg::PCU_WORD_BYTES,
  parameter logic [ADDR_W-1:0] RESET_PC = pcu_pkg::PCU_RESET_PC
) (
  input  logic              rst,
  input  logic [ADDR_W-1:0] pc_cur,
  output logic [ADDR_W-1:0] pc_nxt
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] seq_addr;

  always_comb begin
    seq_addr = pc_cur + STEP_V;
    pc_nxt   = rst ? RESET_PC : seq_addr;
  end
endmodule

// File: rtl/pcu_reg.sv
module pcu_reg #(
  parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W,
  parameter logic [ADDR_W-1:0] RESET_PC = pcu_pkg::PCU_RESET_PC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    q <= d;
  end

  // R2
  reset_load_chk: assert property (@(posedge clk) rst |=> q == RESET_PC)
    else $error("pc not loaded with reset value");

  // R4
  pc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> q == $past(d))
    else $error("pc did not take pre-edge next value");
endmodule

// File: rtl/pcu_fetch.sv
module pcu_fetch #(
  parameter int unsigned ADDR_W = pcu_pkg::PCU_ADDR_W,
  parameter int unsigned DATA_W = pcu_pkg::PCU_DATA_W,
  parameter int unsigned STEP = pcu_pkg::PCU_WORD_BYTES,
  parameter logic [ADDR_W-1:0] RESET_PC = pcu_pkg::PCU_RESET_PC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] imem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] instr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;

  pcu_next #(.ADDR_W(ADDR_W), .STEP(STEP), .RESET_PC(RESET_PC)) u_next (
    .rst    (rst),
    .pc_cur (pc_q),
    .pc_nxt (pc_d)
  );

  pcu_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_reg (
    .clk (clk),
    .rst (rst),
    .d   (pc_d),
    .q   (pc_q)
  );

  assign pc         = pc_q;
  assign fetch_addr = pc_d;
  assign instr      = imem_rdata;

  // R1
  reset_addr_chk: assert property (@(posedge clk) rst |-> fetch_addr == RESET_PC)
    else $error("fetch address not at reset value during reset");

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == $past(pc) + STEP_V)
    else $error("pc did not advance by one word");
endmodule

// File: tb/test_pcu_fetch.sv
module test_pcu_fetch;
  localparam logic [31:0] RST_A = 32'h003F_FFFC;
  localparam logic [31:0] RST_B = 32'hFFFF_FFF4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] rom_a, rom_b;
  logic [31:0] pc_a, fa_a, ins_a, pc_b, fa_b, ins_b;
  int unsigned tests = 0, fails = 0, cyc = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] rom_word(input logic [31:0] a);
    return {a[17:2] ^ 16'hA5C3, ~a[15:0]} + 32'h1357_9BDF;
  endfunction

  pcu_fetch i_pcu_fetch (.clk(clk), .rst(rst), .imem_rdata(rom_a),
    .pc(pc_a), .fetch_addr(fa_a), .instr(ins_a));

  pcu_fetch #(.RESET_PC(RST_B)) i_pcu_fetch_wrap (.clk(clk), .rst(rst),
    .imem_rdata(rom_b), .pc(pc_b), .fetch_addr(fa_b), .instr(ins_b));

  always @(posedge clk) begin
    rom_a <= rom_word(fa_a);
    rom_b <= rom_word(fa_b);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1", fa_a, RST_A);
      chk("R2", pc_a, RST_A);
    end
  endtask

  task automatic run_seq(input int n);
    logic [31:0] base = RST_A + 32'd4;
    rst = 1'b0;
    #0;
    chk("R5 first fetch", fa_a, 32'h0040_0000);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk("R5", pc_a, base + 32'(4 * (k - 1)));
      chk("R3", fa_a, pc_a + 32'd4);
      chk("R6", ins_a, rom_word(pc_a));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset(2);
    run_seq(8);
    // R8: reset mid-run, then restart
    do_reset(1);
    run_seq(5);
    // R7: wrap instance, released together with the run above
    do_reset(2);
    rst = 1'b0;
    #0;
    chk("R7 wrap first", fa_b, RST_B + 32'd4);
    @(negedge clk); chk("R7", pc_b, 32'hFFFF_FFF8);
    @(negedge clk); chk("R7", pc_b, 32'hFFFF_FFFC);
    chk("R7 fetch wraps", fa_b, 32'h0000_0000);
    @(negedge clk); chk("R7", pc_b, 32'h0000_0000);
    chk("R6 wrap word", ins_b, rom_word(32'h0000_0000));
    @(negedge clk); chk("R7", pc_b, 32'h0000_0004);
    // R8 and R5 with random lengths
    for (int t = 0; t < 20; t++) begin
      do_reset(1 + ($urandom % 3));
      run_seq(1 + ($urandom % 40));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule